// File: doc/BRIEF.md
# Reorder Buffer with Precise Exception and Interrupt Entry

This block keeps the program order of in-flight instructions in a 16-slot circular buffer. Instructions are allocated in order at the tail. Execution units then mark them finished in any order, using the slot tag returned at allocation. The oldest slot retires once it is finished, at most one per cycle. The head pointer and the tail pointer each carry an extra wrap bit, so a full buffer and an empty buffer can be told apart.

Full instruction addresses are not stored per slot. The block keeps one base address register, loaded with the address of the first instruction that enters an empty buffer. Each slot then holds a short offset from that base and the instruction length. From these the block rebuilds both the instruction's own address and the address of the following instruction.

The retirement logic settles every event at the head, never at completion:
- A fault flushes the whole buffer.
- A trap retires its instruction and then flushes.
- A resolved mispredicted branch retires and redirects fetch.
- An external interrupt, sampled only at the head, discards all unretired work at once.

For a fault, trap or interrupt, the block requests a drain of the retired stores. Handler entry, with the saved address and a cause code, is signalled only after the drain is acknowledged.

Allocation is a valid/ready stream. An offer holds its address, length and store flag until accepted, and it is accepted on a clock edge where both `alloc_valid` and `alloc_ready` are high. `alloc_ready` never looks at `alloc_valid`, but it does depend on the offered address through the offset window. Completion, retire, flush, redirect and handler-entry signals are single-cycle indications with no back-pressure.

Top module: `rob_precise`

## Requirements
- R1: With all 16 slots occupied, `alloc_ready` is low. Successive accepted allocations receive consecutive slot tags modulo 16 on `alloc_tag`.
- R2: Retirement follows allocation order, at most one slot per cycle, and only for a finished head. `ret_pc` is the instruction address and `ret_store` is its store flag.
- R3: A younger slot that finishes first does not retire until every older slot has finished and retired.
- R4: A fault raises nothing at completion. When the faulting slot reaches the finished head, it is not retired. `flush` pulses, and handler entry follows with `hnd_pc` equal to the faulting address and `hnd_cause` = 1.
- R5: A trap at the finished head retires the slot and flushes. Handler entry follows with `hnd_pc` equal to the address plus the instruction length, and `hnd_cause` = 2.
- R6: An interrupt seen while the head slot is present but not finished flushes all slots in that same cycle, without retiring any. Handler entry follows with `hnd_pc` equal to the head address and `hnd_cause` = 3.
- R7: When the interrupt is seen while the head is a finished mispredicted branch, that branch retires, the rest is flushed, and handler entry carries the branch's corrected target with `hnd_cause` = 3.
- R8: Without an interrupt, a finished mispredicted branch at the head retires, flushes, and pulses `redir_valid` with the corrected target. No drain is requested.
- R9: After a fault, trap or interrupt flush, `drain_req` stays high until `drain_ack`, and `hnd_valid` pulses in the acknowledge cycle. While the drain is pending, nothing allocates, retires or flushes.
- R10: A finished faulting head wins over an interrupt present in the same cycle (cause 1, faulting address).
- R11: While the buffer is not empty, `alloc_ready` is low for any address below the base or more than 255 above it. The base is reloaded when the buffer is empty.
- R12: An interrupt is not taken while the buffer is empty or while a drain is pending. It is taken once an instruction sits at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation offer |
| alloc_ready | output | 1 | Allocation can be accepted |
| alloc_pc | input | 32 | Instruction address of the offer |
| alloc_len | input | 4 | Instruction length in bytes |
| alloc_store | input | 1 | Instruction is a store |
| alloc_tag | output | 4 | Slot tag given to the offer |
| cmp_valid | input | 1 | Completion writeback |
| cmp_tag | input | 4 | Slot being completed |
| cmp_fault | input | 1 | Instruction faulted |
| cmp_trap | input | 1 | Instruction traps after executing |
| cmp_misp | input | 1 | Branch was mispredicted |
| cmp_target | input | 32 | Corrected branch target |
| irq | input | 1 | External interrupt request (level) |
| ret_valid | output | 1 | A slot retires this cycle |
| ret_tag | output | 4 | Retiring slot |
| ret_pc | output | 32 | Address of the retiring instruction |
| ret_store | output | 1 | Retiring instruction is a store |
| flush | output | 1 | Discard all unretired slots |
| redir_valid | output | 1 | Fetch redirect after a mispredict |
| redir_pc | output | 32 | Redirect address |
| drain_req | output | 1 | Request drain of retired stores |
| drain_ack | input | 1 | Drain finished |
| hnd_valid | output | 1 | Handler entry |
| hnd_pc | output | 32 | Saved program counter |
| hnd_cause | output | 2 | 1 fault, 2 trap, 3 interrupt |

## Verification
The in-RTL assertions check the structural rules on every cycle:
- pointers never overrun or underrun;
- only a finished head retires;
- a finished faulting head always flushes without retiring;
- a redirect always comes with a retire and a flush;
- a pending drain holds until acknowledged and stays silent.

The bench scenarios alone can show the rest. These are the saved addresses for each event kind, the priority of fault over interrupt, the choice to retire a resolved mispredict on an interrupt, the stall outside the offset window, and in-order retirement after out-of-order completion.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_FAULT = 2'd1,
    CAUSE_TRAP  = 2'd2,
    CAUSE_IRQ   = 2'd3
  } cause_e;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_DRAIN = 1'b1
  } rstate_e;

  typedef struct packed {
    logic fault;
    logic trap;
    logic misp;
  } exc_flags_t;

endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             clear,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             empty,
  output logic             full
);

  logic [IDX_W:0] hd_q, tl_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      hd_q <= '0;
      tl_q <= '0;
    end else begin
      if (push) tl_q <= tl_q + 1'b1;
      if (pop)  hd_q <= hd_q + 1'b1;
    end
  end

  assign head_idx = hd_q[IDX_W-1:0];
  assign tail_idx = tl_q[IDX_W-1:0];
  assign empty    = (hd_q == tl_q);
  assign full     = (hd_q[IDX_W] != tl_q[IDX_W]) &&
                    (hd_q[IDX_W-1:0] == tl_q[IDX_W-1:0]);

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  parameter int OFF_W = 8,
  parameter int LEN_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             al_we,
  input  logic [IDX_W-1:0] al_idx,
  input  logic [OFF_W-1:0] al_off,
  input  logic [LEN_W-1:0] al_len,
  input  logic             al_store,
  input  logic             cm_we,
  input  logic [IDX_W-1:0] cm_idx,
  input  exc_flags_t       cm_flg,
  input  logic [PC_W-1:0]  cm_tgt,
  input  logic             pop,
  input  logic [IDX_W-1:0] hd_idx,
  output logic             hd_vld,
  output logic             hd_done,
  output exc_flags_t       hd_flg,
  output logic             hd_store,
  output logic [OFF_W-1:0] hd_off,
  output logic [LEN_W-1:0] hd_len,
  output logic [PC_W-1:0]  hd_tgt
);

  logic             vld_q   [DEPTH];
  logic             done_q  [DEPTH];
  exc_flags_t       flg_q   [DEPTH];
  logic             store_q [DEPTH];
  logic [OFF_W-1:0] off_q   [DEPTH];
  logic [LEN_W-1:0] len_q   [DEPTH];
  logic [PC_W-1:0]  tgt_q   [DEPTH];

  logic [DEPTH-1:0] al_hit, cm_hit, pop_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign al_hit[i]  = al_we && (al_idx == IDX_W'(i));
    assign cm_hit[i]  = cm_we && (cm_idx == IDX_W'(i)) && vld_q[i];
    assign pop_hit[i] = pop   && (hd_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        vld_q[i]   <= 1'b0;
        done_q[i]  <= 1'b0;
        flg_q[i]   <= '0;
        store_q[i] <= 1'b0;
        off_q[i]   <= '0;
        len_q[i]   <= '0;
        tgt_q[i]   <= '0;
      end else if (al_hit[i]) begin
        vld_q[i]   <= 1'b1;
        done_q[i]  <= 1'b0;
        flg_q[i]   <= '0;
        store_q[i] <= al_store;
        off_q[i]   <= al_off;
        len_q[i]   <= al_len;
      end else begin
        if (pop_hit[i]) begin
          vld_q[i]  <= 1'b0;
          done_q[i] <= 1'b0;
        end else if (cm_hit[i]) begin
          done_q[i] <= 1'b1;
          flg_q[i]  <= cm_flg;
          tgt_q[i]  <= cm_tgt;
        end
      end
    end
  end

  assign hd_vld   = vld_q[hd_idx];
  assign hd_done  = done_q[hd_idx];
  assign hd_flg   = flg_q[hd_idx];
  assign hd_store = store_q[hd_idx];
  assign hd_off   = off_q[hd_idx];
  assign hd_len   = len_q[hd_idx];
  assign hd_tgt   = tgt_q[hd_idx];

endmodule

// File: rtl/rob_retire_ctl.sv
module rob_retire_ctl
  import rob_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hd_vld,
  input  logic            hd_done,
  input  exc_flags_t      hd_flg,
  input  logic [PC_W-1:0] hd_addr,
  input  logic [PC_W-1:0] hd_next,
  input  logic [PC_W-1:0] hd_tgt,
  input  logic            irq,
  input  logic            drain_ack,
  output logic            retire,
  output logic            flush,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_pc,
  output logic            busy,
  output logic            drain_req,
  output logic            hnd_valid,
  output logic [PC_W-1:0] hnd_pc,
  output logic [1:0]      hnd_cause
);

  rstate_e         st_q;
  cause_e          cause_q, ev_cause;
  logic [PC_W-1:0] pc_q, ev_pc;
  logic            ev, head_rdy;

  assign head_rdy = hd_vld && hd_done;

  always_comb begin
    retire      = 1'b0;
    flush       = 1'b0;
    redir_valid = 1'b0;
    redir_pc    = hd_tgt;
    ev          = 1'b0;
    ev_cause    = CAUSE_NONE;
    ev_pc       = hd_addr;
    if (st_q == ST_RUN) begin
      if (head_rdy && hd_flg.fault) begin
        flush    = 1'b1;
        ev       = 1'b1;
        ev_cause = CAUSE_FAULT;
      end else if (head_rdy && hd_flg.trap) begin
        retire   = 1'b1;
        flush    = 1'b1;
        ev       = 1'b1;
        ev_cause = CAUSE_TRAP;
        ev_pc    = hd_next;
      end else if (irq && hd_vld) begin
        flush    = 1'b1;
        ev       = 1'b1;
        ev_cause = CAUSE_IRQ;
        if (head_rdy && hd_flg.misp) begin
          retire = 1'b1;
          ev_pc  = hd_tgt;
        end
      end else if (head_rdy) begin
        retire = 1'b1;
        if (hd_flg.misp) begin
          flush       = 1'b1;
          redir_valid = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      cause_q <= CAUSE_NONE;
      pc_q    <= '0;
    end else if (st_q == ST_RUN) begin
      if (ev) begin
        st_q    <= ST_DRAIN;
        cause_q <= ev_cause;
        pc_q    <= ev_pc;
      end
    end else if (drain_ack) begin
      st_q <= ST_RUN;
    end
  end

  assign busy      = (st_q == ST_DRAIN);
  assign drain_req = busy;
  assign hnd_valid = busy && drain_ack;
  assign hnd_pc    = pc_q;
  assign hnd_cause = cause_q;

  // R2
  retire_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (hd_vld && hd_done));

  // R4
  fault_no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hd_vld && hd_done && hd_flg.fault) |-> (flush && !retire));

  // R8
  redirect_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (retire && flush && !ev));

  // R9
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_req && !drain_ack) |=> drain_req);

  // R9
  drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!retire && !flush && !redir_valid));

  // R9
  drain_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drain_req) |-> $past(flush));

endmodule

// File: rtl/rob_precise.sv
module rob_precise
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  parameter int OFF_W = 8,
  parameter int LEN_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  input  logic [PC_W-1:0]  alloc_pc,
  input  logic [LEN_W-1:0] alloc_len,
  input  logic             alloc_store,
  output logic [IDX_W-1:0] alloc_tag,
  input  logic             cmp_valid,
  input  logic [IDX_W-1:0] cmp_tag,
  input  logic             cmp_fault,
  input  logic             cmp_trap,
  input  logic             cmp_misp,
  input  logic [PC_W-1:0]  cmp_target,
  input  logic             irq,
  output logic             ret_valid,
  output logic [IDX_W-1:0] ret_tag,
  output logic [PC_W-1:0]  ret_pc,
  output logic             ret_store,
  output logic             flush,
  output logic             redir_valid,
  output logic [PC_W-1:0]  redir_pc,
  output logic             drain_req,
  input  logic             drain_ack,
  output logic             hnd_valid,
  output logic [PC_W-1:0]  hnd_pc,
  output logic [1:0]       hnd_cause
);

  logic [IDX_W-1:0] head_idx, tail_idx;
  logic             empty, full, push, busy, off_ok;
  logic [PC_W-1:0]  base_q, diff, hd_addr, hd_next, hd_tgt;
  logic             hd_vld, hd_done, hd_store;
  exc_flags_t       hd_flg, cm_flg;
  logic [OFF_W-1:0] hd_off, al_off;
  logic [LEN_W-1:0] hd_len;

  // Offset window: the slot stores only alloc_pc - base.
  assign diff        = alloc_pc - base_q;
  assign off_ok      = empty || (diff[PC_W-1:OFF_W] == '0);
  assign al_off      = empty ? '0 : diff[OFF_W-1:0];
  assign alloc_ready = !busy && !full && !flush && off_ok;
  assign push        = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_idx;

  always_ff @(posedge clk) begin
    if (!rst_n)             base_q <= '0;
    else if (push && empty) base_q <= alloc_pc;
  end

  assign hd_addr = base_q + PC_W'(hd_off);
  assign hd_next = hd_addr + PC_W'(hd_len);
  assign cm_flg  = '{fault: cmp_fault, trap: cmp_trap, misp: cmp_misp};

  rob_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(ret_valid), .clear(flush),
    .head_idx(head_idx), .tail_idx(tail_idx), .empty(empty), .full(full)
  );

  rob_entry_array #(.DEPTH(DEPTH), .PC_W(PC_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .clear(flush),
    .al_we(push), .al_idx(tail_idx), .al_off(al_off), .al_len(alloc_len),
    .al_store(alloc_store),
    .cm_we(cmp_valid), .cm_idx(cmp_tag), .cm_flg(cm_flg), .cm_tgt(cmp_target),
    .pop(ret_valid), .hd_idx(head_idx),
    .hd_vld(hd_vld), .hd_done(hd_done), .hd_flg(hd_flg), .hd_store(hd_store),
    .hd_off(hd_off), .hd_len(hd_len), .hd_tgt(hd_tgt)
  );

  rob_retire_ctl #(.PC_W(PC_W)) u_ret (
    .clk(clk), .rst_n(rst_n),
    .hd_vld(hd_vld), .hd_done(hd_done), .hd_flg(hd_flg),
    .hd_addr(hd_addr), .hd_next(hd_next), .hd_tgt(hd_tgt),
    .irq(irq), .drain_ack(drain_ack),
    .retire(ret_valid), .flush(flush),
    .redir_valid(redir_valid), .redir_pc(redir_pc),
    .busy(busy), .drain_req(drain_req),
    .hnd_valid(hnd_valid), .hnd_pc(hnd_pc), .hnd_cause(hnd_cause)
  );

  assign ret_tag   = head_idx;
  assign ret_pc    = hd_addr;
  assign ret_store = hd_store;

  // R12
  irq_needs_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !busy) |=> !drain_req);

endmodule

// File: tb/rob_precise_tb.sv
module rob_precise_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid, alloc_ready, alloc_store;
  logic [31:0] alloc_pc;
  logic [3:0]  alloc_len, alloc_tag;
  logic        cmp_valid, cmp_fault, cmp_trap, cmp_misp;
  logic [3:0]  cmp_tag;
  logic [31:0] cmp_target;
  logic        irq;
  logic        ret_valid, ret_store, flush, redir_valid;
  logic [3:0]  ret_tag;
  logic [31:0] ret_pc, redir_pc, hnd_pc;
  logic        drain_req, drain_ack, hnd_valid;
  logic [1:0]  hnd_cause;

  always #4 clk = ~clk;

  rob_precise u_dut (.*);

  typedef struct {
    int          kind;   // 0 retire, 1 flush, 2 redirect, 3 handler
    logic [31:0] pc;
    logic [1:0]  aux;    // store flag for retire, cause for handler
    string       req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input logic [31:0] pc,
                           input logic [1:0] aux, input string req);
    exp_t e;
    e.kind = kind; e.pc = pc; e.aux = aux; e.req = req;
    q.push_back(e);
  endtask

  task automatic sb_take(input int kind, input logic [31:0] pc, input logic [1:0] aux);
    exp_t e;
    if (q.size() == 0) begin
      chk(1'b0, "unexpected", $sformatf("event kind %0d", kind), pc, 32'h0);
    end else begin
      e = q.pop_front();
      chk(e.kind == kind, e.req, "event kind", kind, e.kind);
      chk(e.pc == pc && e.aux == aux, e.req, $sformatf("kind %0d pc/aux", kind),
          {pc[29:0], aux}, {e.pc[29:0], e.aux});
    end
  endtask

  // Monitor: compares design events against the expected queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (ret_valid)   sb_take(0, ret_pc, {1'b0, ret_store});
      if (flush)       sb_take(1, 32'h0, 2'b00);
      if (redir_valid) sb_take(2, redir_pc, 2'b00);
      if (hnd_valid)   sb_take(3, hnd_pc, hnd_cause);
    end
  end

  // Store-drain responder with checks on the pending window.
  initial begin
    drain_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && drain_req) begin
        repeat (2) begin
          @(negedge clk);
          chk(drain_req == 1'b1, "R9", "drain_req held", drain_req, 1);
          chk(alloc_ready == 1'b0, "R9", "alloc_ready during drain", alloc_ready, 0);
        end
        @(posedge clk); #1 drain_ack = 1'b1;
        @(posedge clk); #1 drain_ack = 1'b0;
      end
    end
  end

  task automatic do_alloc(input logic [31:0] pc, input logic [3:0] len,
                          input logic st, output logic [3:0] tag);
    alloc_valid = 1'b1; alloc_pc = pc; alloc_len = len; alloc_store = st;
    @(negedge clk);
    while (!alloc_ready) @(negedge clk);
    tag = alloc_tag;
    @(posedge clk); #1 alloc_valid = 1'b0;
  endtask

  task automatic do_cmp(input logic [3:0] tag, input logic f, input logic t,
                        input logic m, input logic [31:0] tgt);
    cmp_valid = 1'b1; cmp_tag = tag; cmp_fault = f; cmp_trap = t;
    cmp_misp = m; cmp_target = tgt;
    @(posedge clk); #1;
    cmp_valid = 1'b0; cmp_fault = 1'b0; cmp_trap = 1'b0; cmp_misp = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sb_wait(input string req);
    int n = 0;
    while (q.size() != 0 && n < 300) begin
      @(posedge clk);
      n++;
    end
    @(posedge clk); #1;
    chk(q.size() == 0, req, "pending expected events", q.size(), 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [3:0] t0, t1, t2;
    logic [3:0] tg [16];
    rst_n = 1'b0; alloc_valid = 1'b0; alloc_pc = '0; alloc_len = '0;
    alloc_store = 1'b0; cmp_valid = 1'b0; cmp_tag = '0; cmp_fault = 1'b0;
    cmp_trap = 1'b0; cmp_misp = 1'b0; cmp_target = '0; irq = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // Reset state
    @(negedge clk);
    chk(alloc_ready == 1'b1, "R1", "reset alloc_ready", alloc_ready, 1);
    chk(!ret_valid && !flush && !drain_req && !hnd_valid, "R9", "reset outputs quiet",
        {ret_valid, flush, drain_req, hnd_valid}, 0);
    @(posedge clk); #1;

    // R2 / R3: out-of-order completion, in-order retirement with store flag
    do_alloc(32'h1000, 4'd4, 1'b0, t0);
    do_alloc(32'h1004, 4'd4, 1'b1, t1);
    do_alloc(32'h1008, 4'd2, 1'b0, t2);
    chk(t1 == t0 + 4'd1 && t2 == t0 + 4'd2, "R1", "consecutive tags", {t1, t2}, {t0 + 4'd1, t0 + 4'd2});
    expect_ev(0, 32'h1000, 2'b00, "R2");
    expect_ev(0, 32'h1004, 2'b01, "R2");
    expect_ev(0, 32'h1008, 2'b00, "R3");
    do_cmp(t2, 0, 0, 0, 0);
    @(negedge clk);
    chk(ret_valid == 1'b0, "R3", "young slot held back", ret_valid, 0);
    @(posedge clk); #1;
    do_cmp(t1, 0, 0, 0, 0);
    do_cmp(t0, 0, 0, 0, 0);
    sb_wait("R3");

    // R4: fault reported only at the head
    do_alloc(32'h2000, 4'd4, 1'b0, t0);
    do_alloc(32'h2004, 4'd4, 1'b0, t1);
    do_alloc(32'h2008, 4'd4, 1'b0, t2);
    do_cmp(t1, 1, 0, 0, 0);
    idle(2);
    @(negedge clk);
    chk(flush == 1'b0 && drain_req == 1'b0, "R4", "no flush at fault completion", flush, 0);
    @(posedge clk); #1;
    expect_ev(0, 32'h2000, 2'b00, "R4");
    expect_ev(1, 32'h0, 2'b00, "R4");
    expect_ev(3, 32'h2004, 2'd1, "R4");
    do_cmp(t2, 0, 0, 0, 0);
    do_cmp(t0, 0, 0, 0, 0);
    sb_wait("R4");

    // R5: trap saves the following address
    do_alloc(32'h3000, 4'd3, 1'b0, t0);
    expect_ev(0, 32'h3000, 2'b00, "R5");
    expect_ev(1, 32'h0, 2'b00, "R5");
    expect_ev(3, 32'h3003, 2'd2, "R5");
    do_cmp(t0, 0, 1, 0, 0);
    sb_wait("R5");

    // R6: interrupt discards unfinished work at once
    do_alloc(32'h4000, 4'd4, 1'b0, t0);
    do_alloc(32'h4004, 4'd4, 1'b0, t1);
    expect_ev(1, 32'h0, 2'b00, "R6");
    expect_ev(3, 32'h4000, 2'd3, "R6");
    irq = 1'b1;
    sb_wait("R6");
    // R12: irq held with an empty buffer is not taken
    idle(4);
    @(negedge clk);
    chk(flush == 1'b0 && drain_req == 1'b0, "R12", "irq ignored while empty",
        {flush, drain_req}, 0);
    @(posedge clk); #1;
    expect_ev(1, 32'h0, 2'b00, "R12");
    expect_ev(3, 32'h4100, 2'd3, "R12");
    do_alloc(32'h4100, 4'd4, 1'b0, t0);
    sb_wait("R12");
    irq = 1'b0;

    // R7: interrupt meets a finished mispredicted branch
    do_alloc(32'h5000, 4'd4, 1'b0, t0);
    do_alloc(32'h5004, 4'd4, 1'b0, t1);
    expect_ev(0, 32'h5000, 2'b00, "R7");
    expect_ev(1, 32'h0, 2'b00, "R7");
    expect_ev(3, 32'h6000, 2'd3, "R7");
    cmp_valid = 1'b1; cmp_tag = t0; cmp_misp = 1'b1; cmp_target = 32'h6000;
    @(posedge clk); #1;
    cmp_valid = 1'b0; cmp_misp = 1'b0; irq = 1'b1;
    sb_wait("R7");
    irq = 1'b0;

    // R8: plain mispredict redirects, no drain
    do_alloc(32'h7000, 4'd4, 1'b0, t0);
    do_alloc(32'h7004, 4'd4, 1'b0, t1);
    expect_ev(0, 32'h7000, 2'b00, "R8");
    expect_ev(1, 32'h0, 2'b00, "R8");
    expect_ev(2, 32'h7100, 2'b00, "R8");
    do_cmp(t1, 0, 0, 0, 0);
    do_cmp(t0, 0, 0, 1, 32'h7100);
    sb_wait("R8");
    @(negedge clk);
    chk(drain_req == 1'b0, "R8", "no drain after redirect", drain_req, 0);
    @(posedge clk); #1;

    // R10: fault beats a same-cycle interrupt
    do_alloc(32'h8000, 4'd4, 1'b0, t0);
    expect_ev(1, 32'h0, 2'b00, "R10");
    expect_ev(3, 32'h8000, 2'd1, "R10");
    cmp_valid = 1'b1; cmp_tag = t0; cmp_fault = 1'b1;
    @(posedge clk); #1;
    cmp_valid = 1'b0; cmp_fault = 1'b0; irq = 1'b1;
    sb_wait("R10");
    irq = 1'b0;

    // R11: offset window around the base
    do_alloc(32'h9000, 4'd4, 1'b0, t0);
    alloc_pc = 32'h90FF;
    @(negedge clk);
    chk(alloc_ready == 1'b1, "R11", "offset 255 accepted", alloc_ready, 1);
    @(posedge clk); #1 alloc_pc = 32'h9100;
    @(negedge clk);
    chk(alloc_ready == 1'b0, "R11", "offset 256 stalls", alloc_ready, 0);
    @(posedge clk); #1 alloc_pc = 32'h8FFC;
    @(negedge clk);
    chk(alloc_ready == 1'b0, "R11", "below base stalls", alloc_ready, 0);
    @(posedge clk); #1;
    expect_ev(0, 32'h9000, 2'b00, "R11");
    do_cmp(t0, 0, 0, 0, 0);
    sb_wait("R11");
    alloc_pc = 32'h9100;
    @(negedge clk);
    chk(alloc_ready == 1'b1, "R11", "rebase when empty", alloc_ready, 1);
    @(posedge clk); #1;

    // R1: fill all 16 slots, then retire them in order
    for (int i = 0; i < 16; i++) begin
      do_alloc(32'hA000 + 32'(i * 4), 4'd4, 1'b0, tg[i]);
      chk(tg[i] == tg[0] + 4'(i), "R1", "tag sequence", tg[i], tg[0] + 4'(i));
    end
    alloc_pc = 32'hA040;
    @(negedge clk);
    chk(alloc_ready == 1'b0, "R1", "full stalls allocation", alloc_ready, 0);
    @(posedge clk); #1;
    for (int i = 0; i < 16; i++) expect_ev(0, 32'hA000 + 32'(i * 4), 2'b00, "R2");
    for (int i = 15; i >= 0; i--) do_cmp(tg[i], 0, 0, 0, 0);
    sb_wait("R2");

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule